// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a memory burst. When a read or write command is accepted, the controller pulses `start_i` and presents three values with it: the starting column, a 3-bit length code and the ordering choice. From the next clock onward the block puts out one column per cycle on `col_o`, with `valid_o` high. On the final beat of a fixed-length burst it also raises `last_o`.

Fixed bursts of 2, 4 and 8 beats stay inside the aligned block that contains the starting column. In linear order the low bits count up and wrap at the block boundary. In interleaved order the low bits are the starting column XOR the beat index. A full-page burst is allowed only in linear order. It counts through the whole 1024-column row, wraps around, and keeps running until it is stopped or replaced. A stop input cuts any burst short. A new start on any cycle abandons the running burst and begins the new one at once, with no spacing rule.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no command, `valid_o`, `last_o` and `col_o` are all zero. `col_o` reads zero whenever `valid_o` is low.
- R2: In the clock cycle after the edge that samples `start_i` high, `valid_o` is 1 and `col_o` equals the sampled starting column.
- R3: In linear order (`interleave_i`=0) with a length of 2, 4 or 8 beats, beat n outputs the starting column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits stay unchanged.
- R4: In interleaved order (`interleave_i`=1) with a length of 2, 4 or 8 beats, beat n outputs the starting column XOR n.
- R5: Length codes are 000=1, 001=2, 010=4 and 011=8 beats. `last_o` is high exactly on the final beat and only together with `valid_o`. Unless a new start arrives, `valid_o` is low in the cycle after the final beat.
- R6: Code 111 in linear order is full page. The column is start + n mod 1024, so it wraps from 1023 to 0. `last_o` is never raised, and the burst runs until it is stopped or replaced.
- R7: Codes 100, 101 and 110, and code 111 in interleaved order, all behave as a 1-beat burst.
- R8: If `stop_i` is sampled high while `valid_o` is 1 and `start_i` is 0, the beat on display is the final one and `valid_o` is low in the next cycle. `stop_i` has no effect while idle.
- R9: If `start_i` is sampled high during a running burst, the next cycle shows beat 0 of the new burst. `start_i` wins over `stop_i` when both are high on the same edge.
- R10: Changes to `start_col_i`, `len_code_i` and `interleave_i` without `start_i` do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a new burst command |
| start_col_i | input | 10 | Starting column of the new burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 = linear order, 1 = interleaved order |
| stop_i | input | 1 | Terminate the running burst after the current beat |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is on `col_o` |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its default 10-bit column width, which makes a page exactly 1024 columns. This lets a full-page burst run past column 1023 and wrap to 0, and it allows a single full-page burst to run longer than a whole page, confirming that `last_o` never appears. The starting columns are chosen close to the aligned block edges, so the linear-order wrap and the interleaved XOR pattern each show up within a few beats. Restarts, stops and input changes are timed against a behavioural model that is compared on every cycle.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
  localparam int LEN_W = 3;
  localparam int LOG_W = 2;

  typedef enum logic [LEN_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_FULL = 3'b111
  } len_code_e;
endpackage

// File: rtl/col_seq_decode.sv
module col_seq_decode
  import col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  logic [LOG_W-1:0] log_len;

  always_comb begin
    log_len = '0;
    full_o  = 1'b0;
    case (len_code_i)
      LEN_2:    log_len = 2'd1;
      LEN_4:    log_len = 2'd2;
      LEN_8:    log_len = 2'd3;
      LEN_FULL: full_o  = ~interleave_i; // illegal in interleave -> length 1
      default:  log_len = '0;
    endcase
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (int'(log_len) > i);
  end
endmodule

// File: rtl/col_seq_ctrl.sv
module col_seq_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             interleave_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o
);
  logic full_q;

  assign last_o = active_o & ~full_q & (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      beat_o   <= '0;
      base_o   <= '0;
      mask_o   <= '0;
      full_q   <= 1'b0;
      ilv_o    <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
      base_o   <= start_col_i;
      mask_o   <= mask_i;
      full_q   <= full_i;
      ilv_o    <= interleave_i;
    end else if (active_o) begin
      if (stop_i || last_o) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else begin
        beat_o <= beat_o + 1'b1; // full page wraps at 2**COL_W
      end
    end
  end
endmodule

// File: rtl/col_seq_addr.sv
module col_seq_addr #(
  parameter int COL_W = 10
) (
  input  logic             active_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] lin_col;
  logic [COL_W-1:0] ilv_col;

  assign sum     = base_i + beat_i;
  assign lin_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (beat_i & mask_i);
  assign col_o   = !active_i ? '0 : (ilv_i ? ilv_col : lin_col);
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             active_q;

  col_seq_decode #(.COL_W(COL_W)) u_decode (
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .mask_o       (mask_d),
    .full_o       (full_d)
  );

  col_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .start_col_i  (start_col_i),
    .mask_i       (mask_d),
    .full_i       (full_d),
    .interleave_i (interleave_i),
    .active_o     (active_q),
    .last_o       (last_o),
    .base_o       (base_q),
    .beat_o       (beat_q),
    .mask_o       (mask_q),
    .ilv_o        (ilv_q)
  );

  col_seq_addr #(.COL_W(COL_W)) u_addr (
    .active_i (active_q),
    .ilv_i    (ilv_q),
    .base_i   (base_q),
    .beat_i   (beat_q),
    .mask_i   (mask_q),
    .col_o    (col_o)
  );

  assign valid_o = active_q;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R5
  AST_IDLE_COL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> col_o == '0); // R1
  AST_START_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R2
  AST_START_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(start_col_i)); // R9
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o); // R5
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && stop_i && !start_i |=> !valid_o); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o); // R8
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       ilv = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] col;
  logic       valid;
  logic       last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  bit m_act = 0;
  int m_col = 0, m_len = 1, m_beat = 0;
  bit m_ilv = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .start_col_i(start_col),
    .len_code_i(len_code), .interleave_i(ilv), .stop_i(stop),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  function automatic int len_of(input logic [2:0] c, input bit il);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return il ? 1 : 1024;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int base;
    if (!m_act) return 0;
    if (m_ilv) return m_col ^ m_beat;
    if (m_len == 1024) return (m_col + m_beat) % 1024;
    base = (m_col / m_len) * m_len;
    return base + ((m_col - base + m_beat) % m_len);
  endfunction

  function automatic bit exp_last();
    return m_act && m_len != 1024 && m_beat == m_len - 1;
  endfunction

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_ni) m_act = 0;
    else if (start) begin
      m_act = 1; m_beat = 0; m_col = int'(start_col);
      m_ilv = ilv; m_len = len_of(len_code, ilv);
    end else if (m_act) begin
      if (stop || exp_last()) begin m_act = 0; m_beat = 0; end
      else m_beat = (m_beat + 1) % 1024;
    end
    #1;
    if (rst_ni && !done) begin
      check(tag, int'(valid), int'(m_act), "valid_o");
      check(tag, int'(col), exp_col(), "col_o");
      check(tag, int'(last), int'(exp_last()), "last_o");
    end
  end

  task automatic go(input logic [9:0] c, input logic [2:0] code, input bit il);
    @(negedge clk);
    start = 1; start_col = c; len_code = code; ilv = il;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(3);
    // R1: during reset
    check("R1", int'(valid), 0, "valid_o in reset");
    check("R1", int'(last), 0, "last_o in reset");
    check("R1", int'(col), 0, "col_o in reset");
    rst_ni = 1;
    wait_n(3);
    check("R1", int'(valid) + int'(last) + int'(col), 0, "outputs after reset");

    tag = "R2"; go(10'h155, 3'b000, 0); wait_n(3);
    tag = "R5"; go(10'h020, 3'b001, 0); wait_n(4);
    go(10'h041, 3'b010, 0); wait_n(6);
    tag = "R3"; go(10'h3FD, 3'b011, 0); wait_n(10);
    go(10'h016, 3'b010, 0); wait_n(6);
    go(10'h0E7, 3'b001, 0); wait_n(4);
    tag = "R4"; go(10'h0A5, 3'b011, 1); wait_n(10);
    go(10'h1F6, 3'b010, 1); wait_n(6);
    go(10'h003, 3'b001, 1); wait_n(4);
    tag = "R6"; go(10'd1020, 3'b111, 0); wait_n(12);
    @(negedge clk) stop = 1; @(negedge clk) stop = 0; wait_n(3);
    go(10'd7, 3'b111, 0); wait_n(1100);
    @(negedge clk) stop = 1; @(negedge clk) stop = 0; wait_n(3);
    tag = "R7"; go(10'h111, 3'b100, 0); wait_n(3);
    go(10'h222, 3'b101, 1); wait_n(3);
    go(10'h333, 3'b110, 0); wait_n(3);
    go(10'h0C4, 3'b111, 1); wait_n(3);
    tag = "R8"; go(10'h048, 3'b011, 0); wait_n(2);
    @(negedge clk) stop = 1; @(negedge clk) stop = 0; wait_n(4);
    @(negedge clk) stop = 1; @(negedge clk) stop = 0; wait_n(3);
    tag = "R9"; go(10'h100, 3'b011, 0); wait_n(2);
    go(10'h2F3, 3'b010, 1); wait_n(1);
    go(10'h0FF, 3'b111, 0); wait_n(5);
    @(negedge clk); start = 1; stop = 1; start_col = 10'h01D; len_code = 3'b011; ilv = 0;
    @(negedge clk); start = 0; stop = 0; wait_n(10);
    tag = "R10"; go(10'h08B, 3'b011, 1); wait_n(1);
    @(negedge clk); start_col = 10'h3FF; len_code = 3'b111; ilv = 0;
    wait_n(10);
    finish_run();
  end
endmodule